// File: doc/BRIEF.md
# Channel-Merging Sort Network

This block takes one batch of events per clock, one event on each lane, and reorders the batch by channel number through a pipelined compare-exchange network. An event has a valid bit, a sequence number, a replaced flag, a non-data-replaced flag, a data word and a channel number. If two valid events in one batch name the same channel, the network folds them into a single valid event and marks that event as the product of a merge. The event with the lower sequence number is dropped.

The comparator schedule is built at elaboration time from the lane count. Lane counts must be powers of two. Each comparator layer has a register behind it, so the latency in clocks equals the number of layers. There is no ready signal and no back-pressure. Every clock edge takes a new batch, and a lane whose valid bit is low is simply an empty slot. Downstream logic must therefore accept every batch on the clock edge it appears.

Top module: `chsort_net`

## Requirements
- R1: A batch driven before a clock edge appears on the outputs after exactly 3 clock edges with 4 lanes. Batches may be driven on consecutive clocks.
- R2: While `rst` is high at a clock edge, every output valid bit is 0 after that edge. After `rst` falls, outputs stay invalid until the first batch has crossed the pipeline.
- R3: If no two valid inputs share a channel and no two invalid inputs share a channel, each output lane is an unchanged copy of one input lane. All fields are preserved. Lanes are ordered with valid ones first, and within each group by ascending channel.
- R4: Every channel carried by at least one valid input appears on exactly one valid output. The number of valid outputs equals the number of distinct channels among the valid inputs.
- R5: The valid output for a channel carries the sequence number and data of the valid input on that channel with the largest sequence number. Sequence numbers are distinct within one channel.
- R6: The replaced flag (`out_rep`) is 1 on a valid output that absorbed at least one other event. On a valid output that absorbed nothing, it keeps the value it arrived with.
- R7: On a merged valid output, `out_ndro` is 1 only when all events folded into it carried identical data, and none of them arrived with the replaced flag set but `ndro` clear. Otherwise it is 0.
- R8: A channel carried only by invalid inputs never appears on a valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | LANES | Event present on each lane |
| in_seq | input | LANES x SEQ_W | Sequence number per lane |
| in_rep | input | LANES | Replaced flag per lane |
| in_ndro | input | LANES | Non-data-replaced flag per lane |
| in_chan | input | LANES x CHAN_W | Channel number per lane |
| in_data | input | LANES x DATA_W | Data word per lane |
| out_valid | output | LANES | Event present on each output lane |
| out_seq | output | LANES x SEQ_W | Sequence number per output lane |
| out_rep | output | LANES | Replaced flag per output lane |
| out_ndro | output | LANES | Non-data-replaced flag per output lane |
| out_chan | output | LANES x CHAN_W | Channel number per output lane |
| out_data | output | LANES x DATA_W | Data word per output lane |

## Verification
The bench builds the default configuration: 4 lanes, a 3-bit channel, a 4-bit sequence number and 32-bit data. That gives a three-layer network in which the two-lane, cross-pair and final middle comparators can all be reached. With only eight channel values and four lanes, the bench can drive two-way, paired and four-way collisions. It can also drive invalid-only channels and a valid event that shares its channel with an invalid event. A 4-bit sequence number leaves room to place the largest sequence number on any lane of a colliding group.

// File: rtl/chsort_pkg.sv
package chsort_pkg;

  typedef enum logic [1:0] {
    CX_PASS  = 2'd0,
    CX_SWAP  = 2'd1,
    CX_MERGE = 2'd2
  } cx_act_e;

  // Width of one packed lane: valid, rep, ndro, seq, chan, data.
  function automatic int lane_width(input int seq_w, input int data_w, input int chan_w);
    return 3 + seq_w + data_w + chan_w;
  endfunction

  // Number of comparator layers for a power-of-two lane count.
  function automatic int net_depth(input int n);
    int lg;
    lg = $clog2(n);
    return lg * (lg + 1) / 2;
  endfunction

  // Block size p of layer s.
  function automatic int layer_p(input int n, input int s);
    int cnt;
    int res;
    cnt = 0;
    res = 1;
    for (int p = 1; p < n; p = p * 2)
      for (int k = p; k >= 1; k = k / 2) begin
        if (cnt == s) res = p;
        cnt++;
      end
    return res;
  endfunction

  // Comparator distance k of layer s.
  function automatic int layer_k(input int n, input int s);
    int cnt;
    int res;
    cnt = 0;
    res = 1;
    for (int p = 1; p < n; p = p * 2)
      for (int k = p; k >= 1; k = k / 2) begin
        if (cnt == s) res = k;
        cnt++;
      end
    return res;
  endfunction

  // True when lane x is the lower input of a comparator in layer s.
  function automatic bit lane_is_low(input int n, input int s, input int x);
    int p;
    int k;
    int off;
    p = layer_p(n, s);
    k = layer_k(n, s);
    if (x < 0 || x + k >= n) return 1'b0;
    if ((x / (2 * p)) != ((x + k) / (2 * p))) return 1'b0;
    off = x - (k % p);
    if (off < 0) return 1'b0;
    return (off % (2 * k)) < k;
  endfunction

  // True when lane x is the upper input of a comparator in layer s.
  function automatic bit lane_is_high(input int n, input int s, input int x);
    int k;
    k = layer_k(n, s);
    if (x < k) return 1'b0;
    return lane_is_low(n, s, x - k);
  endfunction

endpackage

// File: rtl/chsort_cx.sv
module chsort_cx
  import chsort_pkg::*;
#(
  parameter int SEQ_W  = 4,
  parameter int DATA_W = 32,
  parameter int CHAN_W = 3,
  localparam int LANE_W = lane_width(SEQ_W, DATA_W, CHAN_W)
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] lo_o,
  output logic [LANE_W-1:0] hi_o
);
  localparam int OFF_CHAN = DATA_W;
  localparam int OFF_SEQ  = DATA_W + CHAN_W;
  localparam int OFF_NDRO = OFF_SEQ + SEQ_W;
  localparam int OFF_REP  = OFF_NDRO + 1;
  localparam int OFF_VLD  = OFF_REP + 1;

  logic              va, vb;
  logic [SEQ_W-1:0]  sa, sb;
  logic [CHAN_W-1:0] ca, cb;
  logic [DATA_W-1:0] da, db;
  logic              clean_a, clean_b;
  logic [CHAN_W:0]   key_a, key_b;
  logic              b_wins;
  cx_act_e           act;

  assign va = a_i[OFF_VLD];
  assign vb = b_i[OFF_VLD];
  assign sa = a_i[OFF_SEQ +: SEQ_W];
  assign sb = b_i[OFF_SEQ +: SEQ_W];
  assign ca = a_i[OFF_CHAN +: CHAN_W];
  assign cb = b_i[OFF_CHAN +: CHAN_W];
  assign da = a_i[DATA_W-1:0];
  assign db = b_i[DATA_W-1:0];

  // An event is "clean" when every replacement it has seen kept its data.
  assign clean_a = ~a_i[OFF_REP] | a_i[OFF_NDRO];
  assign clean_b = ~b_i[OFF_REP] | b_i[OFF_NDRO];

  // Invalid events sort after all valid ones.
  assign key_a  = {~va, ca};
  assign key_b  = {~vb, cb};
  assign b_wins = sb > sa;

  always_comb begin
    if (va && vb && (ca == cb))  act = CX_MERGE;
    else if (key_b < key_a)      act = CX_SWAP;
    else                         act = CX_PASS;
  end

  always_comb begin
    lo_o = a_i;
    hi_o = b_i;
    unique case (act)
      CX_SWAP: begin
        lo_o = b_i;
        hi_o = a_i;
      end
      CX_MERGE: begin
        lo_o = b_wins ? b_i : a_i;
        hi_o = b_wins ? a_i : b_i;
        lo_o[OFF_REP]  = 1'b1;
        lo_o[OFF_NDRO] = (da == db) & clean_a & clean_b;
        hi_o[OFF_VLD]  = 1'b0;
      end
      default: begin
        lo_o = a_i;
        hi_o = b_i;
      end
    endcase
  end

endmodule

// File: rtl/chsort_layer.sv
module chsort_layer
  import chsort_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int STAGE  = 0,
  parameter int SEQ_W  = 4,
  parameter int DATA_W = 32,
  parameter int CHAN_W = 3,
  localparam int LANE_W = lane_width(SEQ_W, DATA_W, CHAN_W)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LANES-1:0][LANE_W-1:0] d_i,
  output logic [LANES-1:0][LANE_W-1:0] q_o
);
  localparam int K        = layer_k(LANES, STAGE);
  localparam int OFF_REP  = DATA_W + CHAN_W + SEQ_W + 1;
  localparam int OFF_VLD  = OFF_REP + 1;

  logic [LANE_W-1:0] mix [LANES];

  for (genvar x = 0; x < LANES; x++) begin : g_lane
    if (lane_is_low(LANES, STAGE, x)) begin : g_cx
      chsort_cx #(
        .SEQ_W (SEQ_W),
        .DATA_W(DATA_W),
        .CHAN_W(CHAN_W)
      ) u_cx (
        .a_i (d_i[x]),
        .b_i (d_i[x+K]),
        .lo_o(mix[x]),
        .hi_o(mix[x+K])
      );
    end else if (!lane_is_high(LANES, STAGE, x)) begin : g_thru
      assign mix[x] = d_i[x];
    end
  end

  // Payload registers load every clock; only the valid bits are reset.
  always_ff @(posedge clk) begin
    for (int x = 0; x < LANES; x++) begin
      q_o[x] <= mix[x];
      if (rst) q_o[x][OFF_VLD] <= 1'b0;
    end
  end

  logic [LANES-1:0] vin, vq, rin, rq;
  always_comb begin
    for (int x = 0; x < LANES; x++) begin
      vin[x] = d_i[x][OFF_VLD];
      vq[x]  = q_o[x][OFF_VLD];
      rin[x] = d_i[x][OFF_REP];
      rq[x]  = q_o[x][OFF_REP];
    end
  end

  AST_VALID_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
    $countones(vq) <= $past($countones(vin))); // R4

  AST_REP_NEVER_LOST: assert property (@(posedge clk) disable iff (rst)
    $countones(rq) >= $past($countones(rin))); // R6

endmodule

// File: rtl/chsort_net.sv
module chsort_net
  import chsort_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int SEQ_W  = 4,
  parameter int DATA_W = 32,
  parameter int CHAN_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LANES-1:0]             in_valid,
  input  logic [LANES-1:0][SEQ_W-1:0]  in_seq,
  input  logic [LANES-1:0]             in_rep,
  input  logic [LANES-1:0]             in_ndro,
  input  logic [LANES-1:0][CHAN_W-1:0] in_chan,
  input  logic [LANES-1:0][DATA_W-1:0] in_data,
  output logic [LANES-1:0]             out_valid,
  output logic [LANES-1:0][SEQ_W-1:0]  out_seq,
  output logic [LANES-1:0]             out_rep,
  output logic [LANES-1:0]             out_ndro,
  output logic [LANES-1:0][CHAN_W-1:0] out_chan,
  output logic [LANES-1:0][DATA_W-1:0] out_data
);
  localparam int LANE_W = lane_width(SEQ_W, DATA_W, CHAN_W);
  localparam int STAGES = net_depth(LANES);

  logic [LANES-1:0][LANE_W-1:0] pipe [STAGES+1];

  always_comb begin
    for (int x = 0; x < LANES; x++)
      pipe[0][x] = {in_valid[x], in_rep[x], in_ndro[x], in_seq[x], in_chan[x], in_data[x]};
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_layer
    chsort_layer #(
      .LANES (LANES),
      .STAGE (s),
      .SEQ_W (SEQ_W),
      .DATA_W(DATA_W),
      .CHAN_W(CHAN_W)
    ) u_layer (
      .clk(clk),
      .rst(rst),
      .d_i(pipe[s]),
      .q_o(pipe[s+1])
    );
  end

  always_comb begin
    for (int x = 0; x < LANES; x++)
      {out_valid[x], out_rep[x], out_ndro[x], out_seq[x], out_chan[x], out_data[x]} = pipe[STAGES][x];
  end

  logic dup_chan;
  always_comb begin
    dup_chan = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (out_valid[i] && out_valid[j] && (out_chan[i] == out_chan[j])) dup_chan = 1'b1;
  end

  AST_OUT_CHAN_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    !dup_chan); // R4

  AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0)); // R2

endmodule

// File: tb/tb_chsort_net.sv
`timescale 1ns/1ps
module tb_chsort_net;
  localparam int LANES = 4;
  localparam int SEQ_W = 4;
  localparam int DATA_W = 32;
  localparam int CHAN_W = 3;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0]             in_valid, in_rep, in_ndro;
  logic [LANES-1:0][SEQ_W-1:0]  in_seq;
  logic [LANES-1:0][CHAN_W-1:0] in_chan;
  logic [LANES-1:0][DATA_W-1:0] in_data;
  logic [LANES-1:0]             out_valid, out_rep, out_ndro;
  logic [LANES-1:0][SEQ_W-1:0]  out_seq;
  logic [LANES-1:0][CHAN_W-1:0] out_chan;
  logic [LANES-1:0][DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chsort_net #(.LANES(LANES), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W)) dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_seq(in_seq), .in_rep(in_rep), .in_ndro(in_ndro),
    .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_seq(out_seq), .out_rep(out_rep), .out_ndro(out_ndro),
    .out_chan(out_chan), .out_data(out_data)
  );

  // Stimulus table, lanes written {lane3, lane2, lane1, lane0}; T_NVAL is the expected valid count.
  localparam logic [3:0] T_VLD [NV] = '{4'b1111, 4'b0101, 4'b0000, 4'b1111, 4'b1111,
                                        4'b1111, 4'b1111, 4'b1010, 4'b1111, 4'b0101};
  localparam logic [3:0] T_REP [NV] = '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
                                        4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001};
  localparam logic [3:0] T_NDR [NV] = '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
                                        4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0011};
  localparam int T_NVAL [NV] = '{4, 2, 0, 3, 3, 1, 1, 1, 2, 2};
  localparam logic [3:0][2:0] T_CHAN [NV] = '{
    {3'd0, 3'd2, 3'd1, 3'd3}, {3'd7, 3'd1, 3'd2, 3'd5}, {3'd1, 3'd0, 3'd6, 3'd4},
    {3'd6, 3'd5, 3'd2, 3'd2}, {3'd1, 3'd4, 3'd0, 3'd4}, {3'd6, 3'd6, 3'd6, 3'd6},
    {3'd3, 3'd3, 3'd3, 3'd3}, {3'd1, 3'd5, 3'd1, 3'd5}, {3'd0, 3'd7, 3'd7, 3'd0},
    {3'd0, 3'd3, 3'd2, 3'd2}};
  localparam logic [3:0][3:0] T_SEQ [NV] = '{
    {4'd4, 4'd3, 4'd2, 4'd1}, {4'd4, 4'd3, 4'd2, 4'd1}, {4'd1, 4'd2, 4'd3, 4'd4},
    {4'd2, 4'd1, 4'd7, 4'd3}, {4'd3, 4'd5, 4'd2, 4'd9}, {4'd1, 4'd5, 4'd8, 4'd2},
    {4'd6, 4'd9, 4'd1, 4'd4}, {4'd6, 4'd7, 4'd2, 4'd0}, {4'd4, 4'd3, 4'd2, 4'd1},
    {4'd7, 4'd3, 4'd5, 4'd1}};
  localparam logic [3:0][31:0] T_DATA [NV] = '{
    {32'h0000_00A3, 32'h0000_00A2, 32'h0000_00A1, 32'h0000_00A0},
    {32'h0000_00B3, 32'h0000_00B2, 32'h0000_00B1, 32'h0000_00B0},
    {32'h0000_00C3, 32'h0000_00C2, 32'h0000_00C1, 32'h0000_00C0},
    {32'h0000_00D3, 32'h0000_00D2, 32'h0000_00D1, 32'h0000_00D0},
    {32'h0000_0E03, 32'h0000_0E01, 32'h0000_0E02, 32'h0000_0E01},
    {32'h5555_0005, 32'h5555_0005, 32'h5555_0005, 32'h5555_0005},
    {32'h6666_0006, 32'h6666_0007, 32'h6666_0006, 32'h6666_0006},
    {32'h0000_00F3, 32'h0000_00F2, 32'h0000_00F1, 32'h0000_00F0},
    {32'h0000_0080, 32'h0000_0082, 32'h0000_0081, 32'h0000_0080},
    {32'h0000_0093, 32'h0000_0092, 32'h0000_0091, 32'h0000_0090}};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input int v);
    in_valid = T_VLD[v];
    in_rep   = T_REP[v];
    in_ndro  = T_NDR[v];
    for (int x = 0; x < LANES; x++) begin
      in_seq[x]  = T_SEQ[v][x];
      in_chan[x] = T_CHAN[v][x];
      in_data[x] = T_DATA[v][x];
    end
  endtask

  task automatic idle();
    in_valid = '0; in_rep = '0; in_ndro = '0;
    in_seq = '0; in_chan = '0; in_data = '0;
  endtask

  function automatic longint pk(input bit v, input bit r, input bit n, input logic [3:0] s,
                                input logic [2:0] c, input logic [31:0] d);
    return longint'({v, r, n, s, c, d});
  endfunction

  function automatic int sort_key(input int v, input int i);
    return (T_VLD[v][i] ? 0 : 8) + int'(T_CHAN[v][i]);
  endfunction

  task automatic check_batch(input int v);
    int nval;
    bit nocol;
    int ord [LANES];
    nval = 0;
    for (int x = 0; x < LANES; x++) if (out_valid[x]) nval++;
    chk(nval == T_NVAL[v], $sformatf("R4 valid count vec%0d", v), nval, T_NVAL[v]);
    nocol = 1'b1;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (T_VLD[v][i] == T_VLD[v][j] && T_CHAN[v][i] == T_CHAN[v][j]) nocol = 1'b0;
    if (nocol) begin
      for (int i = 0; i < LANES; i++) ord[i] = i;
      for (int i = 0; i < LANES; i++)
        for (int j = i + 1; j < LANES; j++)
          if (sort_key(v, ord[j]) < sort_key(v, ord[i])) begin
            int t;
            t = ord[i]; ord[i] = ord[j]; ord[j] = t;
          end
      for (int x = 0; x < LANES; x++) begin
        longint e, a;
        e = pk(T_VLD[v][ord[x]], T_REP[v][ord[x]], T_NDR[v][ord[x]], T_SEQ[v][ord[x]],
               T_CHAN[v][ord[x]], T_DATA[v][ord[x]]);
        a = pk(out_valid[x], out_rep[x], out_ndro[x], out_seq[x], out_chan[x], out_data[x]);
        chk(a == e, $sformatf("R3 vec%0d lane%0d", v, x), a, e);
      end
    end
    for (int i = 0; i < LANES; i++) begin
      if (T_VLD[v][i]) begin
        bit first;
        bit same;
        int size;
        int best;
        int hits;
        int at;
        first = 1'b1;
        for (int j = 0; j < i; j++)
          if (T_VLD[v][j] && T_CHAN[v][j] == T_CHAN[v][i]) first = 1'b0;
        if (first) begin
          size = 0; best = i; same = 1'b1; hits = 0; at = 0;
          for (int j = 0; j < LANES; j++)
            if (T_VLD[v][j] && T_CHAN[v][j] == T_CHAN[v][i]) begin
              size++;
              if (T_SEQ[v][j] > T_SEQ[v][best]) best = j;
            end
          for (int j = 0; j < LANES; j++)
            if (T_VLD[v][j] && T_CHAN[v][j] == T_CHAN[v][i] && T_DATA[v][j] != T_DATA[v][best])
              same = 1'b0;
          for (int x = 0; x < LANES; x++)
            if (out_valid[x] && out_chan[x] == T_CHAN[v][i]) begin
              hits++;
              at = x;
            end
          chk(hits == 1, $sformatf("R4 vec%0d chan%0d hits", v, T_CHAN[v][i]), hits, 1);
          if (hits == 1) begin
            chk(out_seq[at] == T_SEQ[v][best], $sformatf("R5 seq vec%0d", v), out_seq[at], T_SEQ[v][best]);
            chk(out_data[at] == T_DATA[v][best], $sformatf("R5 data vec%0d", v), out_data[at], T_DATA[v][best]);
            if (size > 1) begin
              chk(out_rep[at] == 1'b1, $sformatf("R6 merged vec%0d", v), out_rep[at], 1);
              chk(out_ndro[at] == same, $sformatf("R7 vec%0d", v), out_ndro[at], same);
            end else begin
              chk(out_rep[at] == T_REP[v][i], $sformatf("R6 single vec%0d", v), out_rep[at], T_REP[v][i]);
            end
          end
        end
      end
    end
    for (int x = 0; x < LANES; x++)
      if (out_valid[x]) begin
        bit found;
        found = 1'b0;
        for (int i = 0; i < LANES; i++)
          if (T_VLD[v][i] && T_CHAN[v][i] == out_chan[x]) found = 1'b1;
        chk(found, $sformatf("R8 vec%0d lane%0d", v, x), out_chan[x], -1);
      end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    drive(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0, "R2 during reset", out_valid, 0);
    rst = 1'b0;
    idle();
    // R1: back-to-back batches, each checked three edges after it was driven.
    for (int t = 0; t < NV + 3; t++) begin
      if (t >= 3) check_batch(t - 3);
      if (t < NV) drive(t); else idle();
      @(negedge clk);
    end
    idle();
    repeat (3) @(negedge clk);
    // R1: exact latency of an isolated batch.
    drive(0);
    @(negedge clk); idle();
    chk(out_valid == '0, "R1 after 1 edge", out_valid, 0);
    @(negedge clk);
    chk(out_valid == '0, "R1 after 2 edges", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 4'hF, "R1 after 3 edges", out_valid, 4'hF);
    @(negedge clk);
    chk(out_valid == '0, "R1 after 4 edges", out_valid, 0);
    // R2: reset with the pipeline full, then refill.
    drive(3);
    repeat (3) @(negedge clk);
    chk(out_valid != '0, "R2 pipeline full", out_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R2 reset mid-stream", out_valid, 0);
    drive(5);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R2 refill edge 1", out_valid, 0);
    @(negedge clk);
    chk(out_valid == '0, "R2 refill edge 2", out_valid, 0);
    @(negedge clk);
    chk($countones(out_valid) == 1, "R2 refill edge 3", $countones(out_valid), 1);
    idle();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule